// File: doc/BRIEF.md
# Periodic Countdown Timer with Interrupt

This block is the repeating countdown timer of a real-time-clock register bank. A host programs a 16-bit reload value through a byte-wide register port. It also sets a control byte that picks a tick source, starts counting and enables the interrupt. Single-cycle strobes at each source rate arrive on a tick vector from a prescaler outside the block.

Enabling the timer loads the down-counter from the reload bytes. Each qualifying strobe then counts it down. When the count is exhausted, the timer raises a sticky event flag and reloads, so events repeat at a fixed interval. An active-low interrupt line reports the flag while the interrupt is enabled.

A global timekeeping halt input freezes the slow calendar-derived sources but leaves the fast prescaler tap running. While counting and the interrupt are both off, the reload bytes serve as plain storage.

Top module: `rtc_cycle_timer`

## Requirements
- R1: After reset the reload bytes (addresses 1Bh low, 1Ch high) and the control byte (1Dh) read 00h, and irq_n is 1.
- R2: Any value 00h–FFh written to either reload byte reads back unchanged while run and interrupt enable are both 0.
- R3: The control byte holds the source code in bits [2:0], run in bit 4, interrupt enable in bit 5 and the event flag in bit 7; bits 3 and 6 read 0, and any other address reads 00h.
- R4: A control write that takes run from 0 to 1 loads the counter from the reload value. With reload value P > 0, the flag sets on the (P+1)-th qualifying tick and again every P+1 ticks after that.
- R5: Source code n (0 to 4) selects tick_in[n], where 0 is the fast tap, 1 is 64 Hz, 2 is 1 Hz, 3 is 1 min and 4 is 1 h. Codes 5 to 7 select nothing, and the count holds.
- R6: While stop is 1 and the source code is 1, 2, 3 or 4, ticks are ignored and the count is held, not reset. Counting resumes from the held value once stop returns to 0.
- R7: While stop is 1 and the source code is 0, counting continues normally.
- R8: A reload value of 0 never produces an event.
- R9: irq_n is 0 exactly while the event flag and interrupt enable are both 1.
- R10: A control write with bit 7 = 0 clears the flag; a write with bit 7 = 1 leaves it unchanged.
- R11: An expiring tick in the same cycle as a flag-clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| tick_in | input | 5 | Single-cycle source strobes, index = source code |
| stop | input | 1 | Global timekeeping halt |
| irq_n | output | 1 | Active-low timer interrupt |

## Verification
The bench builds the block with its default parameters: a 16-bit counter split into two 8-bit reload bytes, five tick sources, and the halt mask covering sources 1 to 4. Small reload values keep expiry within a few ticks. This brings repeat periods, halt-and-resume, the zero reload, and the expiry-versus-clear collision within reach of short directed runs. The random phase mixes writes, ticks and halt across all eight source codes.

// File: rtl/rtc_tmr_pkg.sv
package rtc_tmr_pkg;
  localparam int SEL_W         = 3;
  localparam int CTRL_SEL_LSB  = 0;
  localparam int CTRL_RUN_BIT  = 4;
  localparam int CTRL_IE_BIT   = 5;
  localparam int CTRL_FLAG_BIT = 7;

  typedef enum logic [SEL_W-1:0] {
    SRC_FAST = 3'd0,
    SRC_64HZ = 3'd1,
    SRC_1HZ  = 3'd2,
    SRC_1MIN = 3'd3,
    SRC_1HR  = 3'd4
  } tmr_src_e;

  typedef struct packed {
    logic             flag;
    logic             ie;
    logic             run;
    logic [SEL_W-1:0] sel;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile
  import rtc_tmr_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 8,
  parameter int                CNT_W       = 16,
  parameter logic [ADDR_W-1:0] PRESET_ADDR = 8'h1B,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h1D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              event_set,
  output logic [CNT_W-1:0]  preset,
  output tmr_ctrl_t         ctrl,
  output logic              run_rise
);
  localparam int NUM_BYTES = CNT_W / DATA_W;

  logic [NUM_BYTES-1:0][DATA_W-1:0] byte_q;
  logic [NUM_BYTES-1:0]             byte_hit;

  logic             ctrl_wr;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             run_q, run_d;
  logic             ie_q, ie_d;
  logic             flag_q, flag_d;
  logic             flag_en;

  // reload bytes, low byte at the base address
  for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_byte
    assign byte_hit[gi] = wr_en && (addr == ADDR_W'(PRESET_ADDR + ADDR_W'(gi)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q[gi] <= '0;
      end else if (byte_hit[gi]) begin
        byte_q[gi] <= wdata;
      end
    end
  end

  assign preset  = byte_q;
  assign ctrl_wr = wr_en && (addr == CTRL_ADDR);

  always_comb begin
    sel_d = wdata[CTRL_SEL_LSB +: SEL_W];
    run_d = wdata[CTRL_RUN_BIT];
    ie_d  = wdata[CTRL_IE_BIT];
    // expiry wins over a clear in the same cycle
    if (event_set) begin
      flag_d = 1'b1;
    end else begin
      flag_d = 1'b0;
    end
    flag_en = event_set || (ctrl_wr && !wdata[CTRL_FLAG_BIT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      run_q <= 1'b0;
      ie_q  <= 1'b0;
    end else if (ctrl_wr) begin
      sel_q <= sel_d;
      run_q <= run_d;
      ie_q  <= ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign run_rise  = ctrl_wr && wdata[CTRL_RUN_BIT] && !run_q;
  assign ctrl.sel  = sel_q;
  assign ctrl.run  = run_q;
  assign ctrl.ie   = ie_q;
  assign ctrl.flag = flag_q;

  always_comb begin
    rdata = '0;
    if (addr == CTRL_ADDR) begin
      rdata[CTRL_SEL_LSB +: SEL_W] = sel_q;
      rdata[CTRL_RUN_BIT]          = run_q;
      rdata[CTRL_IE_BIT]           = ie_q;
      rdata[CTRL_FLAG_BIT]         = flag_q;
    end
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (addr == ADDR_W'(PRESET_ADDR + ADDR_W'(i))) begin
        rdata = byte_q[i];
      end
    end
  end
endmodule

// File: rtl/tmr_tick_gate.sv
module tmr_tick_gate
  import rtc_tmr_pkg::*;
#(
  parameter int                  NUM_SRC   = 5,
  parameter logic [NUM_SRC-1:0]  STOP_MASK = 5'b11110
) (
  input  logic [NUM_SRC-1:0] tick_in,
  input  logic [SEL_W-1:0]   sel,
  input  logic               run,
  input  logic               stop,
  output logic               tick_q
);
  logic [NUM_SRC-1:0] gated;

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
    if (STOP_MASK[gi]) begin : g_halt
      assign gated[gi] = tick_in[gi] && !stop;
    end else begin : g_free
      assign gated[gi] = tick_in[gi];
    end
  end

  always_comb begin
    tick_q = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel == SEL_W'(i)) begin
        tick_q = gated[i];
      end
    end
    tick_q = tick_q && run;
  end
endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             tick,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    cnt_en = load || tick;
    if (load) begin
      cnt_d = preset;
    end else if (tick) begin
      if (cnt_q == '0) begin
        if (preset != '0) begin
          expire = 1'b1;
          cnt_d  = preset;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/rtc_cycle_timer.sv
module rtc_cycle_timer
  import rtc_tmr_pkg::*;
#(
  parameter int                 ADDR_W      = 8,
  parameter int                 DATA_W      = 8,
  parameter int                 CNT_W       = 16,
  parameter int                 NUM_SRC     = 5,
  parameter logic [NUM_SRC-1:0] STOP_MASK   = 5'b11110,
  parameter logic [ADDR_W-1:0]  PRESET_ADDR = 8'h1B,
  parameter logic [ADDR_W-1:0]  CTRL_ADDR   = 8'h1D
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] tick_in,
  input  logic               stop,
  output logic               irq_n
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [CNT_W-1:0] preset_w;
  logic [CNT_W-1:0] cnt_w;
  tmr_ctrl_t        ctrl_w;
  logic             run_rise_w;
  logic             tick_w;
  logic             expire_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  tmr_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .PRESET_ADDR(PRESET_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .event_set(expire_w), .preset(preset_w), .ctrl(ctrl_w), .run_rise(run_rise_w)
  );

  tmr_tick_gate #(
    .NUM_SRC(NUM_SRC), .STOP_MASK(STOP_MASK)
  ) u_gate (
    .tick_in(tick_in), .sel(ctrl_w.sel), .run(ctrl_w.run),
    .stop(stop), .tick_q(tick_w)
  );

  tmr_down_cnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .load(run_rise_w), .tick(tick_w),
    .preset(preset_w), .cnt(cnt_w), .expire(expire_w)
  );

  assign irq_n = !(ctrl_w.flag && ctrl_w.ie);
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h1D
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              stop,
  input logic [2:0]        sel,
  input logic              flag,
  input logic              tick_w,
  input logic              run_rise_w,
  input logic              expire_w,
  input logic [CNT_W-1:0]  preset_w,
  input logic [CNT_W-1:0]  cnt_w
);
  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    run_rise_w |=> cnt_w == $past(preset_w));

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!tick_w && !run_rise_w) |=> cnt_w == $past(cnt_w));

  assert_halt_gates_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stop && sel >= 3'd1 && sel <= 3'd4) |-> !tick_w);

  assert_bad_code_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel > 3'd4) |-> !tick_w);

  assert_zero_reload_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (preset_w == '0) |-> !expire_w);

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    expire_w |=> flag);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_wr && reg_addr == CTRL_ADDR && !reg_wdata[7] && !expire_w) |=> !flag);
endmodule

bind rtc_cycle_timer tmr_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .stop(stop), .sel(ctrl_w.sel), .flag(ctrl_w.flag),
  .tick_w(tick_w), .run_rise_w(run_rise_w), .expire_w(expire_w),
  .preset_w(preset_w), .cnt_w(cnt_w)
);

// File: tb/rtc_cycle_timer_tb.sv
module rtc_cycle_timer_tb;
  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic [7:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [4:0] tick_in;
  logic       stop;
  logic       irq_n;

  int  n_checks;
  int  n_errors;
  bit  done;

  // bench model state
  logic [7:0]  m_lo, m_hi;
  logic [2:0]  m_sel;
  logic        m_run, m_ie, m_flag;
  logic [15:0] m_cnt;

  rtc_cycle_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_in(tick_in),
    .stop(stop), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    if (a == 8'h1B) return m_lo;
    if (a == 8'h1C) return m_hi;
    if (a == 8'h1D) return {m_flag, 1'b0, m_ie, m_run, 1'b0, m_sel};
    return 8'h00;
  endfunction

  function automatic logic exp_irq_n();
    return !(m_flag && m_ie);
  endfunction

  task automatic model_step(input bit wr, input logic [7:0] a, input logic [7:0] d,
                            input logic [4:0] tk, input bit st);
    logic [15:0] pre;
    bit qual, rise, evt;
    pre  = {m_hi, m_lo};
    qual = m_run && (m_sel < 3'd5) && tk[m_sel] && !(st && m_sel != 3'd0);
    rise = wr && a == 8'h1D && d[4] && !m_run;
    evt  = 1'b0;
    if (rise) m_cnt = pre;
    else if (qual) begin
      if (m_cnt == 16'd0) begin
        if (pre != 16'd0) begin evt = 1'b1; m_cnt = pre; end
      end else m_cnt = m_cnt - 16'd1;
    end
    if (evt) m_flag = 1'b1;
    else if (wr && a == 8'h1D && !d[7]) m_flag = 1'b0;
    if (wr && a == 8'h1B) m_lo = d;
    if (wr && a == 8'h1C) m_hi = d;
    if (wr && a == 8'h1D) begin m_sel = d[2:0]; m_run = d[4]; m_ie = d[5]; end
  endtask

  task automatic check(input string tag, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare after the edge
  task automatic cyc(input string tag, input bit wr, input logic [7:0] a,
                     input logic [7:0] d, input logic [4:0] tk, input bit st);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; tick_in = tk; stop = st;
    model_step(wr, a, d, tk, st);
    @(posedge clk);
    #1;
    check(tag, "irq_n", {7'd0, irq_n}, {7'd0, exp_irq_n()});
    check(tag, "rdata", reg_rdata, exp_read(a));
  endtask

  task automatic wr_reg(input string tag, input logic [7:0] a, input logic [7:0] d);
    cyc(tag, 1'b1, a, d, 5'd0, 1'b0);
  endtask

  task automatic ticks(input string tag, input int n, input logic [4:0] tk, input bit st);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, 8'h1D, 8'h00, tk, st);
  endtask

  task automatic arm(input string tag, input logic [15:0] p, input logic [7:0] c);
    wr_reg(tag, 8'h1D, 8'h00);
    wr_reg(tag, 8'h1B, p[7:0]);
    wr_reg(tag, 8'h1C, p[15:8]);
    wr_reg(tag, 8'h1D, c);
  endtask

  initial begin
    #(4 * 150000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    n_checks = 0; n_errors = 0; done = 1'b0;
    m_lo = 0; m_hi = 0; m_sel = 0; m_run = 0; m_ie = 0; m_flag = 0; m_cnt = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
    tick_in = 5'd0; stop = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state
    cyc("R1", 1'b0, 8'h1B, 8'h00, 5'd0, 1'b0);
    cyc("R1", 1'b0, 8'h1C, 8'h00, 5'd0, 1'b0);
    cyc("R1", 1'b0, 8'h1D, 8'h00, 5'd0, 1'b0);

    // R2: reload bytes as plain storage
    foreach (m_cnt[i]) begin
      logic [7:0] v;
      v = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'((i * 37) ^ 8'hA5);
      wr_reg("R2", 8'h1B, v);
      wr_reg("R2", 8'h1C, ~v);
    end

    // R3: control layout; flag bit write of 1 sets nothing
    wr_reg("R3", 8'h1D, 8'hFF);
    wr_reg("R3", 8'h1D, 8'h00);
    cyc("R3", 1'b0, 8'h42, 8'h00, 5'd0, 1'b0);

    // R4: period P+1 on 64 Hz, then repeat after clear
    arm("R4", 16'd3, 8'hB1);
    ticks("R4", 4, 5'b00010, 1'b0);
    wr_reg("R4", 8'h1D, 8'h31);
    ticks("R4", 4, 5'b00010, 1'b0);

    // R5: each code follows its own tick bit; codes 5..7 hold
    for (int s = 0; s < 8; s++) begin
      arm("R5", 16'd1, 8'hB0 | 8'(s));
      ticks("R5", 2, 5'b11111 & ~(5'd1 << s), 1'b0);
      ticks("R5", 2, 5'b11111, 1'b0);
    end

    // R6: halt freezes slow source, count held, resume finishes
    for (int s = 1; s < 5; s++) begin
      arm("R6", 16'd3, 8'hB0 | 8'(s));
      ticks("R6", 2, 5'd1 << s, 1'b0);
      ticks("R6", 6, 5'b11111, 1'b1);
      ticks("R6", 2, 5'd1 << s, 1'b0);
    end

    // R7: halt does not affect the fast tap
    arm("R7", 16'd2, 8'hB0);
    ticks("R7", 3, 5'b00001, 1'b1);

    // R8: zero reload never fires
    arm("R8", 16'd0, 8'hB1);
    ticks("R8", 10, 5'b00010, 1'b0);

    // R9: flag set while interrupt disabled keeps irq_n high, enable exposes it
    arm("R9", 16'd1, 8'h92);
    ticks("R9", 2, 5'b00100, 1'b0);
    wr_reg("R9", 8'h1D, 8'hB2);

    // R10: writing 1 to the flag keeps it, writing 0 clears it
    wr_reg("R10", 8'h1D, 8'hB2);
    wr_reg("R10", 8'h1D, 8'h32);

    // R11: expiry and clear in the same cycle
    arm("R11", 16'd1, 8'hB1);
    ticks("R11", 1, 5'b00010, 1'b0);
    cyc("R11", 1'b1, 8'h1D, 8'h31, 5'b00010, 1'b0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit         w;
      logic [7:0] a, d;
      w = ($urandom % 6) == 0;
      case ($urandom % 4)
        0: a = 8'h1B;
        1: a = 8'h1C;
        2: a = 8'h1D;
        default: a = 8'h20;
      endcase
      d = 8'($urandom);
      if (a == 8'h1B) d = d & 8'h07;
      if (a == 8'h1C) d = (($urandom % 8) == 0) ? d : 8'h00;
      cyc("R4", w, a, d, 5'($urandom), ($urandom % 4) == 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule